// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This block watches the instruction fetch stream and raises a debug exception request when a fetch address matches one of its software-programmable breakpoint registers. It holds a parameterised number of breakpoint registers (two by default). Each register is one address word. Bit 0 is the enable, and the upper bits are the address to break on. Software writes and reads the registers through a simple indexed port.

The compare granularity follows the current instruction-set state. In word mode the fetch address and the register are compared on bits 31:2, so bit 1 and bit 0 are don't-care on both sides. In half-word mode the compare covers bits 31:1. A qualified hit needs three things: a valid fetch, the global debug enable high, and at least one enabled register matching. A qualified hit produces a one-cycle request on the clock edge after the fetch, before the instruction is allowed to execute. The same hit loads the method-of-entry code 3'b001 into a status output, which keeps that value afterwards.

The block never clears an enable on its own. A breakpoint therefore fires again on every fetch of its address until software disables it. Register writes are seen by the compare on the following cycle.

Top module: `ibp_match_unit`

## Requirements
- R1: After synchronous active-low reset, `brk_req` is 0, `moe` is 3'b000, and bit 0 (the enable) of every breakpoint register reads 0. The address bits are undefined after reset.
- R2: A write to register `reg_idx` stores `reg_wdata`. From the next cycle, `reg_rdata` returns the stored 32-bit value whenever `reg_idx` selects that register.
- R3: In word mode (`half_mode`=0), an enabled register hits when fetch address bits 31:2 equal register bits 31:2. Fetch bits 1:0 and register bit 1 do not affect the match.
- R4: In half-word mode (`half_mode`=1), an enabled register hits only when fetch address bits 31:1 equal register bits 31:1. A difference in bit 1 means no hit.
- R5: A register whose bit 0 is 0 never causes a hit.
- R6: While `debug_en` is 0, `brk_req` is 0 on the following cycle, whatever the fetch and register contents.
- R7: `brk_req` is 1 in the cycle after a fetch exactly when that fetch had `fetch_valid`=1, `debug_en`=1 and at least one enabled matching register. It is 0 after any other cycle.
- R8: When several registers match the same fetch, that fetch produces a single one-cycle request.
- R9: Each qualified hit sets `moe` to 3'b001 in the same cycle that `brk_req` rises. `moe` changes at no other time.
- R10: The block does not clear an enable after a hit. Fetching the same address again produces a new request.
- R11: A fetch in the same cycle as a register write is compared against the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register index for writes and reads |
| reg_wdata | input | 32 | Write data: bits 31:1 address, bit 0 enable |
| reg_rdata | output | 32 | Contents of the selected register |
| fetch_valid | input | 1 | The fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| half_mode | input | 1 | 1 = half-word compare, 0 = word compare |
| debug_en | input | 1 | Global debug enable |
| brk_req | output | 1 | Debug exception request, one cycle per qualified hit |
| moe | output | 3 | Method-of-entry code, 3'b001 after a breakpoint hit |

## Verification
Directed fetches probe the compare boundaries:
- addresses that differ from a register only in bit 1 or only in bit 2, tried in both modes, separate a word compare from a half-word compare and expose an off-by-one compare range;
- the same matching address presented with the enable cleared, with `debug_en` low, or with `fetch_valid` low shows that each qualifier gates the request on its own;
- back-to-back fetches of one address, and a write landing in the same cycle as a fetch, confirm that the enable is never self-cleared and that writes take effect one cycle later.

Randomised traffic then mixes writes, modes and fetches drawn near the programmed addresses, and compares `brk_req`, `moe` and read-back values against a reference model.

// File: rtl/ibp_pkg.sv
// Package: shared constants for the instruction breakpoint match unit.
// Assumes: method-of-entry codes are 3 bits wide.
package ibp_pkg;
    localparam int MOE_W = 3;
    localparam logic [MOE_W-1:0] MOE_NONE   = 3'b000;
    localparam logic [MOE_W-1:0] MOE_IBREAK = 3'b001;

    // Width of an index able to address n entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ibp_regfile.sv
// Module: breakpoint register bank. Each entry holds an address field
// (bits ADDR_W-1:1) and an enable (bit 0). Only the enables are reset.
// Assumes: one write per cycle, asynchronous (combinational) read.
module ibp_regfile #(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    localparam int IDX_W = ibp_pkg::idx_width(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:1] bp_addr [NUM_BP],
    output logic [NUM_BP-1:0] bp_en
);
    logic [ADDR_W-1:1] addr_q [NUM_BP];
    logic [NUM_BP-1:0] en_q;

    // Address fields: loaded on write, no reset value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BP; i++) begin
            if (wr_en && (int'(wr_idx) == i)) addr_q[i] <= wr_data[ADDR_W-1:1];
        end
    end

    // Enable bits: cleared by reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (wr_en && (int'(wr_idx) == i)) en_q[i] <= wr_data[0];
            end
        end
    end

    // Read mux for the selected entry.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            if (int'(rd_idx) == i) rd_data = {addr_q[i], en_q[i]};
        end
    end

    assign bp_addr = addr_q;
    assign bp_en   = en_q;

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && (rd_idx == $past(wr_idx)))
            |-> (rd_data == $past(wr_data)));  // R2
endmodule

// File: rtl/ibp_compare.sv
// Module: address comparator for one breakpoint register.
// Word mode compares bits ADDR_W-1:2; half-word mode compares ADDR_W-1:1.
// Assumes: ADDR_W >= 3; result is purely combinational.
module ibp_compare #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:1] bp_addr,
    input  logic              bp_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              half_mode,
    output logic              hit
);
    logic upper_eq;
    logic bit1_eq;

    // Split compare: the upper field always counts, bit 1 only in half-word mode.
    always_comb begin
        upper_eq = (bp_addr[ADDR_W-1:2] == fetch_addr[ADDR_W-1:2]);
        bit1_eq  = (bp_addr[1] == fetch_addr[1]);
        hit      = bp_en && upper_eq && (bit1_eq || !half_mode);
    end
endmodule

// File: rtl/ibp_match_unit.sv
// Module: instruction breakpoint match unit (top). Compares every fetch
// against NUM_BP programmable breakpoints and raises a one-cycle debug
// exception request on the edge after a qualified hit, recording the
// method-of-entry code. Assumes the pipeline holds the fetched instruction
// until the request has been seen; enables are cleared only by software.
module ibp_match_unit #(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    localparam int IDX_W = ibp_pkg::idx_width(NUM_BP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [IDX_W-1:0]         reg_idx,
    input  logic [ADDR_W-1:0]        reg_wdata,
    output logic [ADDR_W-1:0]        reg_rdata,
    input  logic                     fetch_valid,
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic                     half_mode,
    input  logic                     debug_en,
    output logic                     brk_req,
    output logic [ibp_pkg::MOE_W-1:0] moe
);
    import ibp_pkg::*;

    logic [ADDR_W-1:1] bp_addr [NUM_BP];
    logic [NUM_BP-1:0] bp_en;
    logic [NUM_BP-1:0] bp_hit;
    logic              take_brk;

    ibp_regfile #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata),
        .rd_idx  (reg_idx),
        .rd_data (reg_rdata),
        .bp_addr (bp_addr),
        .bp_en   (bp_en)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        ibp_compare #(.ADDR_W(ADDR_W)) u_cmp (
            .bp_addr    (bp_addr[g]),
            .bp_en      (bp_en[g]),
            .fetch_addr (fetch_addr),
            .half_mode  (half_mode),
            .hit        (bp_hit[g])
        );
    end

    // Qualify the merged hit with the fetch strobe and global enable.
    assign take_brk = fetch_valid && debug_en && (|bp_hit);

    // Register the request and the method-of-entry code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
            moe     <= MOE_NONE;
        end else begin
            brk_req <= take_brk;
            if (take_brk) moe <= MOE_IBREAK;
        end
    end

    AST_REQ_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> ($past(fetch_valid) && $past(debug_en)));  // R7
    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_en |=> !brk_req);  // R6
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> ($past(bp_en) != '0));  // R5
    AST_MOE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (moe == MOE_IBREAK));  // R9
    AST_MOE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(moe) |-> brk_req);  // R9
endmodule

// File: tb/ibp_match_unit_test.sv
module ibp_match_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [0:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        half_mode = 1'b0;
    logic        debug_en = 1'b0;
    logic        brk_req;
    logic [2:0]  moe;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] m_reg [2];
    logic        m_written [2];
    logic [2:0]  m_moe;
    logic        done = 1'b0;

    ibp_match_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .half_mode(half_mode), .debug_en(debug_en),
        .brk_req(brk_req), .moe(moe)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    function automatic logic hit_of(input logic [31:0] r, input logic [31:0] a, input logic hm);
        if (!r[0]) return 1'b0;
        return hm ? (r[31:1] == a[31:1]) : (r[31:2] == a[31:2]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: apply inputs, advance, check request and entry code.
    task automatic step(input logic we, input logic idx, input logic [31:0] wd,
                        input logic fv, input logic [31:0] fa, input logic hm,
                        input logic de, input string req);
        logic exp;
        reg_we = we; reg_idx = idx; reg_wdata = wd;
        fetch_valid = fv; fetch_addr = fa; half_mode = hm; debug_en = de;
        exp = fv && de && (hit_of(m_reg[0], fa, hm) || hit_of(m_reg[1], fa, hm));
        if (we) begin m_reg[idx] = wd; m_written[idx] = 1'b1; end
        if (exp) m_moe = 3'b001;
        @(posedge clk);
        #1;
        reg_we = 1'b0; fetch_valid = 1'b0;
        check(req, {31'd0, brk_req}, {31'd0, exp});
        check(req, {29'd0, moe}, {29'd0, m_moe});
    endtask

    task automatic check_read(input logic idx, input string req);
        reg_idx = idx;
        #0.5;
        if (m_written[idx]) check(req, reg_rdata, m_reg[idx]);
        else check(req, {31'd0, reg_rdata[0]}, {31'd0, m_reg[idx][0]});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        m_reg[0] = '0; m_reg[1] = '0; m_written[0] = 0; m_written[1] = 0; m_moe = 3'b000;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1", {31'd0, brk_req}, 32'd0);
        check("R1", {29'd0, moe}, 32'd0);
        check_read(1'b0, "R1");
        check_read(1'b1, "R1");
        // R2 program and read back
        step(1, 0, 32'h1000_0003, 0, 0, 0, 1, "R2");
        check_read(1'b0, "R2");
        // R3 word mode: bits 1:0 ignored, bit 2 matters
        step(0, 0, 0, 1, 32'h1000_0000, 0, 1, "R3");
        step(0, 0, 0, 1, 32'h1000_0002, 0, 1, "R3");
        step(0, 0, 0, 1, 32'h1000_0004, 0, 1, "R3");
        // R4 half-word mode: bit 1 matters
        step(0, 0, 0, 1, 32'h1000_0002, 1, 1, "R4");
        step(0, 0, 0, 1, 32'h1000_0000, 1, 1, "R4");
        // R10 same address hits again on consecutive fetches
        step(0, 0, 0, 1, 32'h1000_0002, 1, 1, "R10");
        step(0, 0, 0, 1, 32'h1000_0002, 1, 1, "R10");
        // R7 no fetch strobe: no request, pulse lasts one cycle
        step(0, 0, 0, 0, 32'h1000_0002, 1, 1, "R7");
        // R9 code holds after idle
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        // R6 global enable low
        step(0, 0, 0, 1, 32'h1000_0000, 0, 0, "R6");
        // R11 write disabling in the same cycle as the fetch: old value used
        step(1, 0, 32'h1000_0002, 1, 32'h1000_0000, 0, 1, "R11");
        // R5 disabled register no longer hits
        step(0, 0, 0, 1, 32'h1000_0000, 0, 1, "R5");
        // R8 both registers match
        step(1, 0, 32'h2000_0009, 0, 0, 0, 1, "R8");
        step(1, 1, 32'h2000_0009, 0, 0, 0, 1, "R8");
        check_read(1'b1, "R2");
        step(0, 0, 0, 1, 32'h2000_0008, 1, 1, "R8");
        step(0, 0, 0, 0, 0, 1, 1, "R8");
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic we, idx, fv, hm, de;
            logic [31:0] wd, fa;
            we  = ($urandom % 6) == 0;
            idx = $urandom % 2;
            wd  = {$urandom % 4 == 0 ? 28'h2000_000 : 28'h3000_000 | 28'($urandom % 4), 3'($urandom), 1'($urandom)};
            fv  = ($urandom % 4) != 0;
            hm  = $urandom % 2;
            de  = ($urandom % 8) != 0;
            fa  = m_reg[$urandom % 2] ^ {29'd0, 3'($urandom % 8)};
            step(we, idx, wd, fv, fa, hm, de, "R7");
            if ((i % 50) == 0) check_read(idx, "R2");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule